// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file and address decoder of one UART channel. A host drives a 3-bit offset, a read strobe, a write strobe and a write byte. The block returns a read byte combinationally from the current state. Eight offsets are not enough for every control byte, so further banks are switched in by the stored contents of the line, feature and modem control bytes.

The block holds all control bytes and drives each one out as a port. These are the interrupt enable, FIFO control, line control, modem control and scratch bytes, the two divisor bytes, the feature byte, the four flow-control character bytes, and the transmission-control and trigger-level bytes. Receive data, interrupt identity, line status, modem status and FIFO-ready status arrive on inputs and are only multiplexed onto the read bus. Accesses to the holding registers at offset 0 produce one-cycle strobes, which the serial engine consumes.

Top module: `uart_bank_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every control byte to 0x00. The two divisor bytes are the exception and load 0x01.
- R2: With line-control bit 7 at 0, reads at offsets 0 to 7 return, in order: receive data, interrupt enable, interrupt identity, line control, modem control, line status, modem status and scratch.
- R3: With line-control bit 7 at 0, writes store to their slots: offset 1 to interrupt enable, 2 to FIFO control, 4 to modem control and 7 to scratch. A write at offset 0 raises `thr_wstb` and a read at offset 0 raises `rhr_rstb`. Each strobe is high in the same cycle as the access and stores nothing.
- R4: With line-control bit 7 at 1, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte. Neither strobe is raised.
- R5: While line control equals 0xBF, offset 2 reads and writes the feature byte. Offsets 4, 5, 6 and 7 reach the first on-character, second on-character, first off-character and second off-character. This bank takes precedence over every other overlay.
- R6: While feature bit 4 and modem-control bit 6 are both 1, and line control is not 0xBF, offset 6 reaches the transmission-control byte and offset 7 the trigger-level byte. This takes precedence over the FIFO-ready read.
- R7: When both active-low channel selects are low, modem-control bit 2 is 1 and modem-control bit 4 is 0, a read at offset 7 returns `stat_fifordy`, provided no higher bank applies. A write at offset 7 then still goes to scratch.
- R8: A write to modem control updates bit 7 only while feature bit 4 is 1. Otherwise bit 7 keeps its value and bits 6 to 0 update.
- R9: Offset 3 reads and writes line control in every bank.
- R10: Writes at offsets 5 and 6 in the normal bank change no stored byte.
- R11: A write takes effect at the clock edge. A read in the same cycle returns the old value, and the next access decodes with the new bank selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational) |
| csel_a_n | input | 1 | Channel A select, active low |
| csel_b_n | input | 1 | Channel B select, active low |
| stat_rx | input | 8 | Receive data byte |
| stat_iid | input | 8 | Interrupt identity byte |
| stat_line | input | 8 | Line status byte |
| stat_modem | input | 8 | Modem status byte |
| stat_fifordy | input | 8 | FIFO-ready status byte |
| thr_wstb | output | 1 | Transmit holding write strobe |
| rhr_rstb | output | 1 | Receive holding read strobe |
| ier_q | output | 8 | Interrupt enable |
| fcr_q | output | 8 | FIFO control |
| lcr_q | output | 8 | Line control |
| mcr_q | output | 8 | Modem control |
| spr_q | output | 8 | Scratch |
| dll_q | output | 8 | Divisor low byte |
| dlh_q | output | 8 | Divisor high byte |
| efr_q | output | 8 | Feature byte |
| xon1_q | output | 8 | First on-character |
| xon2_q | output | 8 | Second on-character |
| xoff1_q | output | 8 | First off-character |
| xoff2_q | output | 8 | Second off-character |
| tcr_q | output | 8 | Transmission control |
| tlr_q | output | 8 | Trigger level |

## Verification
A read and a write can fall in the same cycle. When the write targets a byte that selects banks, the read must still decode through the old bank, and the next access must use the new one. The bench provokes this in a directed case: it writes line control while reading offset 3, and then reads offset 0 both before and after the switch into the divisor bank. The random phase also issues combined read-write cycles with biased line-control values. Each read byte and each strobe is judged against a bench model, which is updated only after the edge.

// File: rtl/uart_bank_regs.sv
module uart_bank_regs #(
  parameter logic [7:0] ENH_KEY = 8'hBF,
  parameter logic [7:0] DIV_RST = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       csel_a_n,
  input  logic       csel_b_n,
  input  logic [7:0] stat_rx,
  input  logic [7:0] stat_iid,
  input  logic [7:0] stat_line,
  input  logic [7:0] stat_modem,
  input  logic [7:0] stat_fifordy,
  output logic       thr_wstb,
  output logic       rhr_rstb,
  output logic [7:0] ier_q,
  output logic [7:0] fcr_q,
  output logic [7:0] lcr_q,
  output logic [7:0] mcr_q,
  output logic [7:0] spr_q,
  output logic [7:0] dll_q,
  output logic [7:0] dlh_q,
  output logic [7:0] efr_q,
  output logic [7:0] xon1_q,
  output logic [7:0] xon2_q,
  output logic [7:0] xoff1_q,
  output logic [7:0] xoff2_q,
  output logic [7:0] tcr_q,
  output logic [7:0] tlr_q
);

  logic bank_key, bank_div, bank_ext, frdy_on;
  logic [7:0] slot;

  assign bank_key = (lcr_q == ENH_KEY);
  assign bank_div = lcr_q[7];
  assign bank_ext = efr_q[4] & mcr_q[6] & ~bank_key;
  assign frdy_on  = ~csel_a_n & ~csel_b_n & mcr_q[2] & ~mcr_q[4];

  always_comb begin
    slot = '0;
    slot[addr] = 1'b1;
  end

  assign thr_wstb = wr_en & slot[0] & ~bank_div;
  assign rhr_rstb = rd_en & slot[0] & ~bank_div;

  logic we_dll, we_dlh, we_ier, we_efr, we_fcr, we_lcr, we_mcr, we_xon1;
  logic we_xon2, we_xoff1, we_xoff2, we_tcr, we_tlr, we_spr;

  assign we_dll   = wr_en & slot[0] & bank_div;
  assign we_dlh   = wr_en & slot[1] & bank_div;
  assign we_ier   = wr_en & slot[1] & ~bank_div;
  assign we_efr   = wr_en & slot[2] & bank_key;
  assign we_fcr   = wr_en & slot[2] & ~bank_key;
  assign we_lcr   = wr_en & slot[3];
  assign we_xon1  = wr_en & slot[4] & bank_key;
  assign we_mcr   = wr_en & slot[4] & ~bank_key;
  assign we_xon2  = wr_en & slot[5] & bank_key;
  assign we_xoff1 = wr_en & slot[6] & bank_key;
  assign we_tcr   = wr_en & slot[6] & bank_ext;
  assign we_xoff2 = wr_en & slot[7] & bank_key;
  assign we_tlr   = wr_en & slot[7] & bank_ext;
  assign we_spr   = wr_en & slot[7] & ~bank_key & ~bank_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q   <= '0;
      fcr_q   <= '0;
      lcr_q   <= '0;
      mcr_q   <= '0;
      spr_q   <= '0;
      dll_q   <= DIV_RST;
      dlh_q   <= DIV_RST;
      efr_q   <= '0;
      xon1_q  <= '0;
      xon2_q  <= '0;
      xoff1_q <= '0;
      xoff2_q <= '0;
      tcr_q   <= '0;
      tlr_q   <= '0;
    end else begin
      if (we_ier)   ier_q   <= wdata;
      if (we_fcr)   fcr_q   <= wdata;
      if (we_lcr)   lcr_q   <= wdata;
      if (we_mcr)   mcr_q   <= {efr_q[4] ? wdata[7] : mcr_q[7], wdata[6:0]};
      if (we_spr)   spr_q   <= wdata;
      if (we_dll)   dll_q   <= wdata;
      if (we_dlh)   dlh_q   <= wdata;
      if (we_efr)   efr_q   <= wdata;
      if (we_xon1)  xon1_q  <= wdata;
      if (we_xon2)  xon2_q  <= wdata;
      if (we_xoff1) xoff1_q <= wdata;
      if (we_xoff2) xoff2_q <= wdata;
      if (we_tcr)   tcr_q   <= wdata;
      if (we_tlr)   tlr_q   <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      3'd0: rdata = bank_div ? dll_q : stat_rx;
      3'd1: rdata = bank_div ? dlh_q : ier_q;
      3'd2: rdata = bank_key ? efr_q : stat_iid;
      3'd3: rdata = lcr_q;
      3'd4: rdata = bank_key ? xon1_q : mcr_q;
      3'd5: rdata = bank_key ? xon2_q : stat_line;
      3'd6: rdata = bank_key ? xoff1_q : bank_ext ? tcr_q : stat_modem;
      3'd7: rdata = bank_key ? xoff2_q : bank_ext ? tlr_q :
                    frdy_on ? stat_fifordy : spr_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       csel_a_n,
  input logic       csel_b_n,
  input logic [7:0] stat_fifordy,
  input logic       thr_wstb,
  input logic       rhr_rstb,
  input logic [7:0] lcr_q,
  input logic [7:0] mcr_q,
  input logic [7:0] efr_q,
  input logic [7:0] dll_q,
  input logic [7:0] dlh_q
);

  AST_RESET_DIVISOR: assert property (@(posedge clk) rst |=> (dll_q == 8'h01 && dlh_q == 8'h01 && lcr_q == 8'h00)); // R1

  AST_THR_STROBE_SRC: assert property (@(posedge clk) disable iff (rst)
    thr_wstb |-> (wr_en && addr == 3'd0 && !lcr_q[7])); // R3

  AST_RHR_STROBE_SRC: assert property (@(posedge clk) disable iff (rst)
    rhr_rstb |-> (rd_en && addr == 3'd0 && !lcr_q[7])); // R3

  AST_NO_STROBE_DIV: assert property (@(posedge clk) disable iff (rst)
    lcr_q[7] |-> (!thr_wstb && !rhr_rstb)); // R4

  AST_MCR7_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4 && lcr_q != 8'hBF && !efr_q[4]) |=> (mcr_q[7] == $past(mcr_q[7]))); // R8

  AST_LCR_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3) |=> (lcr_q == $past(wdata))); // R9

  AST_FIFORDY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd7 && lcr_q != 8'hBF && !(efr_q[4] && mcr_q[6]) &&
     !csel_a_n && !csel_b_n && mcr_q[2] && !mcr_q[4]) |-> (rdata == stat_fifordy)); // R7

endmodule

bind uart_bank_regs uart_bank_regs_chk u_chk (.*);

// File: tb/uart_bank_regs_bench.sv
module uart_bank_regs_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic [2:0] addr = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic csel_a_n = 1, csel_b_n = 1;
  logic [7:0] stat_rx = 0, stat_iid = 0, stat_line = 0, stat_modem = 0, stat_fifordy = 0;
  logic thr_wstb, rhr_rstb;
  logic [7:0] ier_q, fcr_q, lcr_q, mcr_q, spr_q, dll_q, dlh_q, efr_q;
  logic [7:0] xon1_q, xon2_q, xoff1_q, xoff2_q, tcr_q, tlr_q;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlh, m_efr;
  logic [7:0] m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cycles++;

  uart_bank_regs u_uart_bank_regs (.*);

  task automatic model_reset();
    {m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_efr} = '0;
    {m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr} = '0;
    m_dll = 8'h01; m_dlh = 8'h01;
  endtask

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    logic key, ext, fr;
    key = (m_lcr == 8'hBF);
    ext = m_efr[4] && m_mcr[6] && !key;
    fr  = !csel_a_n && !csel_b_n && m_mcr[2] && !m_mcr[4];
    case (a)
      3'd0: return m_lcr[7] ? m_dll : stat_rx;
      3'd1: return m_lcr[7] ? m_dlh : m_ier;
      3'd2: return key ? m_efr : stat_iid;
      3'd3: return m_lcr;
      3'd4: return key ? m_xon1 : m_mcr;
      3'd5: return key ? m_xon2 : stat_line;
      3'd6: return key ? m_xoff1 : ext ? m_tcr : stat_modem;
      default: return key ? m_xoff2 : ext ? m_tlr : fr ? stat_fifordy : m_spr;
    endcase
  endfunction

  task automatic model_wr(logic [2:0] a, logic [7:0] d);
    logic key, ext;
    key = (m_lcr == 8'hBF);
    ext = m_efr[4] && m_mcr[6] && !key;
    case (a)
      3'd0: if (m_lcr[7]) m_dll = d;
      3'd1: if (m_lcr[7]) m_dlh = d; else m_ier = d;
      3'd2: if (key) m_efr = d; else m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: if (key) m_xon1 = d; else m_mcr = {m_efr[4] ? d[7] : m_mcr[7], d[6:0]};
      3'd5: if (key) m_xon2 = d;
      3'd6: if (key) m_xoff1 = d; else if (ext) m_tcr = d;
      default: if (key) m_xoff2 = d; else if (ext) m_tlr = d; else m_spr = d;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    chk(tag, "regs",
        {ier_q, fcr_q, lcr_q, mcr_q, spr_q, dll_q, dlh_q, efr_q, xon1_q, xon2_q, xoff1_q, xoff2_q, tcr_q, tlr_q},
        {m_ier, m_fcr, m_lcr, m_mcr, m_spr, m_dll, m_dlh, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr});
  endtask

  task automatic cyc(bit rd, bit wr, logic [2:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    stat_rx = 8'($urandom); stat_iid = 8'($urandom); stat_line = 8'($urandom);
    stat_modem = 8'($urandom); stat_fifordy = 8'($urandom);
    #1;
    check_regs(tag);
    if (rd) chk(tag, "rdata", 128'(rdata), 128'(exp_rd(a)));
    chk(tag, "strobes", 128'({thr_wstb, rhr_rstb}),
        128'({wr && a == 3'd0 && !m_lcr[7], rd && a == 3'd0 && !m_lcr[7]}));
    @(posedge clk);
    if (wr) model_wr(a, d);
  endtask

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 0;
    cyc(0, 0, 0, 0, "R1");

    cyc(0, 1, 3, 8'h03, "R9");
    for (int i = 0; i < 8; i++) cyc(1, 0, 3'(i), 0, "R2");
    cyc(0, 1, 1, 8'h5A, "R3");
    cyc(0, 1, 2, 8'hC7, "R3");
    cyc(0, 1, 4, 8'h0B, "R3");
    cyc(0, 1, 7, 8'h3C, "R3");
    cyc(0, 1, 0, 8'h41, "R3");
    cyc(1, 0, 0, 0, "R3");
    cyc(0, 1, 5, 8'hFF, "R10");
    cyc(0, 1, 6, 8'hEE, "R10");
    cyc(1, 0, 1, 0, "R10");

    cyc(1, 1, 3, 8'h83, "R11");
    cyc(1, 0, 0, 0, "R11");
    cyc(0, 1, 0, 8'h34, "R4");
    cyc(0, 1, 1, 8'h12, "R4");
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 0, 1, 0, "R4");
    cyc(1, 0, 2, 0, "R4");

    cyc(0, 1, 3, 8'hBF, "R5");
    cyc(0, 1, 2, 8'h10, "R5");
    cyc(0, 1, 4, 8'h11, "R5");
    cyc(0, 1, 5, 8'h13, "R5");
    cyc(0, 1, 6, 8'h91, "R5");
    cyc(0, 1, 7, 8'h93, "R5");
    for (int i = 0; i < 8; i++) cyc(1, 0, 3'(i), 0, "R5");
    cyc(1, 0, 3, 0, "R9");

    cyc(0, 1, 3, 8'h03, "R8");
    cyc(0, 1, 4, 8'hC0, "R8");
    cyc(1, 0, 4, 0, "R8");
    cyc(0, 1, 6, 8'h77, "R6");
    cyc(0, 1, 7, 8'h66, "R6");
    cyc(1, 0, 6, 0, "R6");
    cyc(1, 0, 7, 0, "R6");
    cyc(0, 1, 3, 8'hBF, "R5");
    cyc(1, 0, 7, 0, "R5");
    cyc(0, 1, 2, 8'h00, "R8");
    cyc(0, 1, 3, 8'h03, "R8");
    cyc(0, 1, 4, 8'h04, "R8");
    cyc(1, 0, 4, 0, "R8");

    csel_a_n = 0; csel_b_n = 0;
    cyc(1, 0, 7, 0, "R7");
    cyc(0, 1, 7, 8'hA5, "R7");
    cyc(1, 0, 7, 0, "R7");
    cyc(0, 1, 4, 8'h14, "R7");
    cyc(1, 0, 7, 0, "R7");
    csel_b_n = 1;
    cyc(0, 1, 4, 8'h04, "R7");
    cyc(1, 0, 7, 0, "R7");

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd3) begin
        case ($urandom % 4)
          0: d = 8'h00;
          1: d = 8'h83;
          2: d = 8'hBF;
          default: ;
        endcase
      end
      csel_a_n = ($urandom % 4) == 0;
      csel_b_n = ($urandom % 4) == 0;
      cyc(1'($urandom), 1'($urandom), a, d, "R11");
    end
    cyc(0, 0, 0, 0, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=below 100000 cycles", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule